// File: doc/BRIEF.md
# Aliased Posted-Write Path

This block sits between a processor's simple request port and a master port on the system bus. Every bus location can be reached at two addresses that differ only in one alias bit. A write through the "posted" alias, while the global buffering enable is set, is placed in a small FIFO and acknowledged at once. The FIFO then writes it out to the bus in the background while the processor carries on. A write through the "direct" alias, any write while buffering is off, and every read are performed on the bus while the processor waits. Such an access is acknowledged only when the bus signals completion.

Program order is kept. A direct access is not started on the bus until every posted write ahead of it has completed, so a read never returns data that an earlier buffered write has not yet reached. The alias bit is always cleared on the downstream address, so both aliases reach the same location. The downstream side carries one transaction at a time, using a valid/ready request and a one-cycle done pulse. An idle flag shows when nothing is queued or in flight, which software fences can poll.

Top module: `posted_write_path`

## Requirements
- R1: While reset is held and in the first cycle after it, `idle` is 1, `bus_valid` is 0 and `cpu_ack` is 0.
- R2: A write (`cpu_we`=1) with address bit `ALIAS_BIT` = 1, made while `buf_en` = 1 and the FIFO is not full, is acknowledged by `cpu_ack` in the same cycle it is requested.
- R3: When `DEPTH` posted writes are waiting, another posted write gets no `cpu_ack` until an entry has completed downstream. It is then accepted.
- R4: Posted writes appear downstream one at a time, in the order they were accepted, with `bus_we`=1 and with the data and byte strobes that were given.
- R5: A write with address bit `ALIAS_BIT` = 0 is acknowledged only in the cycle in which `bus_done` completes that transfer.
- R6: While `buf_en` = 0, a write with address bit `ALIAS_BIT` = 1 behaves like R5: it is not queued and is acknowledged together with `bus_done`.
- R7: A read (`cpu_we`=0) is sent downstream with `bus_we`=0 and is never queued. It is acknowledged together with `bus_done`, and `cpu_rdata` equals `bus_rdata` in that cycle.
- R8: A direct write or read is not started downstream until every earlier posted write has completed there.
- R9: `bus_addr` always has bit `ALIAS_BIT` = 0. All its other bits equal those of the requesting address.
- R10: After a request has been accepted (`bus_valid` and `bus_ready` both high), `bus_valid` stays low until `bus_done` has been seen.
- R11: `idle` is 1 exactly when no posted write is waiting and no downstream transfer is requested or in flight.
- R12: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_we`, `bus_addr`, `bus_wdata` and `bus_be` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| buf_en | input | 1 | Global enable for write posting |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Request address; bit ALIAS_BIT selects the posted alias |
| cpu_wdata | input | DW | Write data |
| cpu_be | input | DW/8 | Byte strobes |
| cpu_ack | output | 1 | One-cycle acknowledge; the processor is stalled while req is high and ack is low |
| cpu_rdata | output | DW | Read data, valid with cpu_ack of a read |
| bus_valid | output | 1 | Downstream request valid |
| bus_ready | input | 1 | Downstream accepts the request |
| bus_we | output | 1 | Downstream write flag |
| bus_addr | output | AW | Downstream address, alias bit cleared |
| bus_wdata | output | DW | Downstream write data |
| bus_be | output | DW/8 | Downstream byte strobes |
| bus_done | input | 1 | One-cycle completion of the outstanding transfer |
| bus_rdata | input | DW | Downstream read data, valid with bus_done |
| idle | output | 1 | Nothing queued and nothing in flight |

## Verification
A long random mix of posted writes, direct writes and reads runs against a downstream responder with random ready and completion delays, and the enable is toggled between accesses. Checking every downstream transfer in program order separates correct ordering and alias stripping from reordering or stale reads. A directed run with the bus frozen fills the FIFO, which separates immediate acknowledgement from stalling on a full FIFO. Directed writes through the posted alias with buffering off, and reads issued behind pending posts, separate the direct path from the queued one.

// File: rtl/pwp_pkg.sv
// Shared types for the posted-write path.
// Assumes: nothing beyond the sequencer's use of the state encoding.
package pwp_pkg;

    // Downstream sequencer states: draining a posted entry or running a direct access.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DRN_REQ,
        SQ_DRN_WAIT,
        SQ_DIR_REQ,
        SQ_DIR_WAIT
    } seq_state_e;

endpackage

// File: rtl/pwp_decode.sv
// Alias decoder: classifies a processor request as posted or direct and
// strips the alias bit from the address.
// Assumes: the request fields are held stable while cpu_req is high.
module pwp_decode #(
    parameter int AW        = 32,
    parameter int ALIAS_BIT = 28
) (
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic          buf_en,
    output logic          want_post,
    output logic          want_direct,
    output logic [AW-1:0] phys_addr
);

    // A write goes to the FIFO only through the posted alias and only while enabled.
    always_comb begin
        want_post   = cpu_req && cpu_we && cpu_addr[ALIAS_BIT] && buf_en;
        want_direct = cpu_req && !want_post;
        phys_addr   = cpu_addr;
        phys_addr[ALIAS_BIT] = 1'b0;
    end

endmodule

// File: rtl/pwp_fifo.sv
// Posting FIFO: holds accepted writes (address, data, strobes) until they
// are drained downstream.
// Assumes: the caller never pushes when full or pops when empty.
module pwp_fifo #(
    parameter int W     = 68,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    // Store the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Advance the pointers with wrap-around and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Present the oldest entry and the occupancy flags.
    always_comb begin
        dout  = mem[rp];
        empty = (cnt == '0);
        full  = (cnt == CW'(DEPTH));
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/pwp_seq.sv
// Downstream sequencer: drains FIFO entries first, then runs one direct access.
// Keeps exactly one transaction outstanding.
// Assumes: bus_done arrives at least one cycle after the valid/ready handshake.
module pwp_seq
    import pwp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_empty,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic [SW-1:0] head_be,
    input  logic          dir_go,
    input  logic          dir_we,
    input  logic [AW-1:0] dir_addr,
    input  logic [DW-1:0] dir_data,
    input  logic [SW-1:0] dir_be,
    input  logic          bus_ready,
    input  logic          bus_done,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic [SW-1:0] bus_be,
    output logic          pop,
    output logic          dir_ack,
    output logic          busy
);

    seq_state_e st, st_nx;

    // Choose the next step; posted entries always go before a direct access.
    always_comb begin
        st_nx = st;
        case (st)
            SQ_IDLE: begin
                if (!fifo_empty)  st_nx = SQ_DRN_REQ;
                else if (dir_go)  st_nx = SQ_DIR_REQ;
            end
            SQ_DRN_REQ:  if (bus_ready) st_nx = SQ_DRN_WAIT;
            SQ_DRN_WAIT: if (bus_done)  st_nx = SQ_IDLE;
            SQ_DIR_REQ:  if (bus_ready) st_nx = SQ_DIR_WAIT;
            SQ_DIR_WAIT: if (bus_done)  st_nx = SQ_IDLE;
            default:     st_nx = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    // Drive the downstream request from the FIFO head or the held processor request.
    always_comb begin
        bus_valid = (st == SQ_DRN_REQ) || (st == SQ_DIR_REQ);
        if (st == SQ_DIR_REQ || st == SQ_DIR_WAIT) begin
            bus_we    = dir_we;
            bus_addr  = dir_addr;
            bus_wdata = dir_data;
            bus_be    = dir_be;
        end else begin
            bus_we    = 1'b1;
            bus_addr  = head_addr;
            bus_wdata = head_data;
            bus_be    = head_be;
        end
        pop     = (st == SQ_DRN_WAIT) && bus_done;
        dir_ack = (st == SQ_DIR_WAIT) && bus_done;
        busy    = (st != SQ_IDLE);
    end

    assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready) |=> !bus_valid);
    assert_hold_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata)
                                       && $stable(bus_we) && $stable(bus_be)));
    assert_direct_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_DIR_REQ) |-> fifo_empty);

endmodule

// File: rtl/posted_write_path.sv
// Top of the aliased posted-write path: decodes the alias, posts writes into
// the FIFO, stalls the processor when needed and sequences the bus master port.
// Assumes: the processor holds cpu_req and its fields until cpu_ack, and the
// downstream side raises bus_done once per accepted request.
module posted_write_path #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int DEPTH     = 4,
    parameter int ALIAS_BIT = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               buf_en,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [DW-1:0]      cpu_wdata,
    input  logic [DW/8-1:0]    cpu_be,
    output logic               cpu_ack,
    output logic [DW-1:0]      cpu_rdata,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic               bus_we,
    output logic [AW-1:0]      bus_addr,
    output logic [DW-1:0]      bus_wdata,
    output logic [DW/8-1:0]    bus_be,
    input  logic               bus_done,
    input  logic [DW-1:0]      bus_rdata,
    output logic               idle
);

    localparam int SW = DW / 8;
    localparam int EW = AW + DW + SW;

    logic          want_post, want_direct;
    logic [AW-1:0] phys_addr;
    logic          fifo_empty, fifo_full, push, pop, dir_ack, busy;
    logic [EW-1:0] head;

    pwp_decode #(.AW(AW), .ALIAS_BIT(ALIAS_BIT)) u_decode (
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .buf_en      (buf_en),
        .want_post   (want_post),
        .want_direct (want_direct),
        .phys_addr   (phys_addr)
    );

    pwp_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({phys_addr, cpu_wdata, cpu_be}),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    pwp_seq #(.AW(AW), .DW(DW), .SW(SW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .head_addr  (head[EW-1 -: AW]),
        .head_data  (head[SW +: DW]),
        .head_be    (head[SW-1:0]),
        .dir_go     (want_direct),
        .dir_we     (cpu_we),
        .dir_addr   (phys_addr),
        .dir_data   (cpu_wdata),
        .dir_be     (cpu_be),
        .bus_ready  (bus_ready),
        .bus_done   (bus_done),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .pop        (pop),
        .dir_ack    (dir_ack),
        .busy       (busy)
    );

    // Accept posted writes while space remains; direct accesses finish with the bus.
    always_comb begin
        push      = want_post && !fifo_full;
        cpu_ack   = push || dir_ack;
        cpu_rdata = bus_rdata;
        idle      = fifo_empty && !busy;
    end

    assert_alias_stripped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !bus_addr[ALIAS_BIT]);
    assert_direct_waits_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && want_direct) |-> bus_done);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!bus_valid && !pop));

endmodule

// File: tb/sim_posted_write_path.sv
module sim_posted_write_path;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int AB = 28;
    localparam int NQ = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_en = 1'b0;
    logic cpu_req = 1'b0;
    logic cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [3:0] cpu_be = '0;
    logic cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic bus_valid, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [3:0] bus_be;
    logic bus_ready = 1'b0;
    logic bus_done = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic idle;

    always #2.5 clk = ~clk;

    posted_write_path #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ALIAS_BIT(AB)) u0 (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .idle(idle)
    );

    // Expected downstream transactions in program order.
    logic [AW-1:0] exp_addr [NQ];
    logic [DW-1:0] exp_data [NQ];
    logic [3:0]    exp_be   [NQ];
    logic          exp_we   [NQ];
    int wr_idx = 0;
    int rd_idx = 0;

    int total = 0;
    int bad = 0;
    int mon_total = 0;
    int mon_bad = 0;
    bit stall_mode = 1'b1;

    function automatic logic [DW-1:0] read_pattern(input logic [AW-1:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [AW-1:0] strip(input logic [AW-1:0] a);
        logic [AW-1:0] r;
        r = a;
        r[AB] = 1'b0;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard of downstream requests plus R10/R12 protocol checks.
    int hs_count = 0;
    logic [AW-1:0] lat_addr = '0;
    bit prev_stuck = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_data = '0;
    logic [3:0] prev_be = '0;
    logic prev_we = 1'b0;
    bit resp_busy = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stuck) begin
                mon_total++;
                if (!(bus_valid && bus_addr == prev_addr && bus_wdata == prev_data &&
                      bus_be == prev_be && bus_we == prev_we)) begin
                    mon_bad++;
                    $display("FAIL R12 held request changed act=%h exp=%h", bus_addr, prev_addr);
                end
            end
            if (bus_valid && resp_busy) begin
                mon_bad++;
                mon_total++;
                $display("FAIL R10 second request while busy act=%h exp=%h", 1, 0);
            end
            if (bus_valid && bus_ready) begin
                mon_total++;
                if (rd_idx >= wr_idx) begin
                    mon_bad++;
                    $display("FAIL R4 unexpected transfer act=%h exp=%h", bus_addr, 32'h0);
                end else if (bus_addr != exp_addr[rd_idx] || bus_we != exp_we[rd_idx] ||
                             (exp_we[rd_idx] && (bus_wdata != exp_data[rd_idx] ||
                                                 bus_be != exp_be[rd_idx]))) begin
                    mon_bad++;
                    $display("FAIL R4 R8 R9 transfer %0d addr act=%h exp=%h data act=%h exp=%h",
                             rd_idx, bus_addr, exp_addr[rd_idx], bus_wdata, exp_data[rd_idx]);
                end
                if (rd_idx < wr_idx) rd_idx++;
                lat_addr = bus_addr;
                hs_count++;
            end
            prev_stuck = bus_valid && !bus_ready;
            prev_addr = bus_addr;
            prev_data = bus_wdata;
            prev_be = bus_be;
            prev_we = bus_we;
        end
    end

    // Downstream responder: random ready, random completion delay, one-cycle done.
    int seen_hs = 0;
    int resp_cnt = 0;
    always @(posedge clk) begin
        #1;
        if (bus_done) begin
            bus_done = 1'b0;
            resp_busy = 1'b0;
        end else if (resp_busy) begin
            if (resp_cnt == 0) begin
                bus_done = 1'b1;
                bus_rdata = read_pattern(lat_addr);
            end else begin
                resp_cnt--;
            end
        end
        if (seen_hs != hs_count) begin
            seen_hs = hs_count;
            resp_busy = 1'b1;
            resp_cnt = int'($urandom % 3);
            bus_ready = 1'b0;
        end else if (!resp_busy && !stall_mode) begin
            bus_ready = ($urandom % 4) != 0;
        end else begin
            bus_ready = 1'b0;
        end
    end

    // Record an expected downstream transfer.
    task automatic expect_xfer(input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input logic [3:0] be, input logic we);
        exp_addr[wr_idx] = strip(a);
        exp_data[wr_idx] = d;
        exp_be[wr_idx] = be;
        exp_we[wr_idx] = we;
        wr_idx++;
    endtask

    // One processor access; waits for acknowledge and checks what it can.
    task automatic cpu_op(input bit we, input bit alias_hi, input logic [AW-1:0] a0,
                          input logic [DW-1:0] d, input logic [3:0] be, input bit chk_fast);
        logic [AW-1:0] a;
        bit posted;
        bit got;
        int waited;
        a = a0;
        a[AB] = alias_hi;
        posted = we && alias_hi && buf_en;
        expect_xfer(a, d, be, we);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        got = 1'b0;
        waited = 0;
        while (!got) begin
            @(negedge clk);
            if (cpu_ack) got = 1'b1;
            else waited++;
        end
        if (posted) begin
            if (chk_fast) check(waited == 0, "R2 posted ack latency", waited, 0);
        end else if (!we) begin
            check(bus_done == 1'b1, "R7 read ack with done", bus_done, 1);
            check(cpu_rdata == read_pattern(strip(a)), "R7 read data", cpu_rdata, read_pattern(strip(a)));
        end else if (alias_hi) begin
            check(bus_done == 1'b1, "R6 disabled alias ack with done", bus_done, 1);
        end else begin
            check(bus_done == 1'b1, "R5 direct ack with done", bus_done, 1);
        end
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        while (n < 100) begin
            @(negedge clk);
            if (idle) break;
            n++;
        end
        check(idle == 1'b1, req, idle, 1);
        check(rd_idx == wr_idx, req, rd_idx, wr_idx);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
        $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed_v;
        bit got;
        int acks;
        seed_v = $urandom(32'h1D5EED);
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(idle == 1'b1, "R1 idle in reset", idle, 1);
        check(bus_valid == 1'b0, "R1 bus_valid in reset", bus_valid, 0);
        check(cpu_ack == 1'b0, "R1 cpu_ack in reset", cpu_ack, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(idle == 1'b1 && bus_valid == 1'b0, "R1 after reset", {idle, bus_valid}, 2'b10);

        // R2/R3: frozen bus, fill the FIFO, then one more post must stall.
        buf_en = 1'b1;
        stall_mode = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            cpu_op(1'b1, 1'b1, 32'h0000_1000 + 32'(i * 4), 32'hA000_0000 + 32'(i), 4'hF, 1'b1);
        @(negedge clk);
        check(idle == 1'b0, "R11 not idle with queued posts", idle, 0);
        check(bus_valid == 1'b1, "R4 drain requested", bus_valid, 1);
        expect_xfer(32'h1000_2000, 32'hBEEF_0005, 4'h3, 1'b1);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h1000_2000;
        cpu_wdata = 32'hBEEF_0005; cpu_be = 4'h3;
        acks = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cpu_ack) acks++;
        end
        check(acks == 0, "R3 post stalled on full FIFO", acks, 0);
        stall_mode = 1'b0;
        got = 1'b0;
        while (!got) begin
            @(negedge clk);
            if (cpu_ack) got = 1'b1;
        end
        check(got, "R3 post accepted after drain", got, 1);
        @(posedge clk); #1;
        cpu_req = 1'b0;

        // R8: a read right behind pending posts sees all of them drained first.
        cpu_op(1'b0, 1'b0, 32'h0000_1004, 32'h0, 4'hF, 1'b0);
        check(rd_idx == wr_idx, "R8 read issued after posts", rd_idx, wr_idx);
        wait_idle("R11 idle after drain");

        // R6: enable off, posted alias behaves as direct.
        buf_en = 1'b0;
        cpu_op(1'b1, 1'b1, 32'h0000_3000, 32'h1234_5678, 4'hC, 1'b0);
        // R5: direct alias write.
        buf_en = 1'b1;
        cpu_op(1'b1, 1'b0, 32'h0000_3004, 32'h8765_4321, 4'h1, 1'b0);
        // R7: read through posted alias is still direct.
        cpu_op(1'b0, 1'b1, 32'h0000_3008, 32'h0, 4'hF, 1'b0);
        wait_idle("R11 idle after direct ops");
        cpu_op(1'b1, 1'b1, 32'h0000_4000, 32'h0000_0042, 4'hF, 1'b1);
        wait_idle("R4 single post drained");

        // Random mix.
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] ra;
            if (($urandom % 16) == 0) buf_en = ~buf_en;
            ra = $urandom;
            cpu_op(($urandom % 3) != 0, $urandom % 2, ra, $urandom, 4'($urandom), 1'b0);
        end
        wait_idle("R11 idle after random mix");
        check(mon_bad == 0, "R10 R12 protocol monitor", mon_bad, 0);

        $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

endmodule